// File: doc/BRIEF.md
# Configurable Edge/Level Interrupt Controller

This block gathers 32 interrupt sources and turns them into two active-high request lines and one wake line. Each source has its own three-bit trigger code. The code selects rising-edge, falling-edge or either-edge capture, active-high or active-low level sensing, or switches the source off. A source reaches a request line only while its enable bit is set. A steering bit chooses which of the two lines it drives. A separate wake-enable bit lets the source drive the wake line even while it is masked. Edge events are caught in two separate capture registers, one for rising and one for falling edges. They stay there until software acknowledges them. Level sources report the live input and are never latched.

Software reaches the block over a small command/response bus with valid/ready handshakes. Every control register has three addresses: one to read it, one where each 1 bit sets that bit, and one where each 1 bit clears it. Software therefore never needs a read-modify-write. Per-source inputs come either from an on-chip vector or from a pin vector. All inputs pass through a two-flop synchronizer. A test register can replace both input vectors for self-test.

The bus applies back-pressure like this. A command is taken on any clock edge where `cmd_valid_i` and `cmd_ready_o` are both high. Each accepted command produces exactly one response on the next cycle. `cmd_ready_o` is low only while a response is waiting and `rsp_ready_i` is low. During that time `rsp_valid_o` and `rsp_data_o` do not change.

Top module: `irq_router`

## Requirements
- R1: After reset, every trigger code, enable, wake-enable, input-select and test bit is 0, every steering bit is 1, both capture registers are 0, `irq_req_o` is 2'b00, `wake_o` is 0 and `rsp_valid_o` is 0.
- R2: A word address is {block[3:0], op[1:0]}. Op 0 reads, op 1 sets and op 2 clears. The blocks are: 0 trigger bit 0, 1 trigger bit 1, 2 trigger bit 2, 3 enable, 4 wake-enable, 5 steering and 6 input-select. On these blocks, each 1 in the write data sets (op 1) or clears (op 2) the matching bit. 0 bits leave their bits unchanged, and op 0 returns the register.
- R3: The trigger code of source n is {bit2[n], bit1[n], bit0[n]}. Code 001 catches 0-to-1 transitions in the rising capture register, which is read at block 7. Code 010 catches 1-to-0 transitions in the falling capture register, which is read at block 8. Code 011 catches both kinds, each kind in its own register.
- R4: A captured bit stays set until software writes a 1 to it at op 2 of block 7 (rising) or block 8 (falling). 0 bits written there have no effect, and an input that returns to its old value does not clear the capture.
- R5: Code 101 makes a source pending while its synchronized input is 1, and code 110 while it is 0. Neither is latched. Codes 000, 100 and 111 never make a source pending.
- R6: A pending, enabled source drives request 0 when its steering bit is 1 and request 1 when it is 0. Reading block 9 returns the pending-enabled-steered-to-0 bitmap, and block 10 returns the bitmap for request 1. Each `irq_req_o` bit is the registered OR of its bitmap.
- R7: A source whose enable bit is 0 appears in neither status bitmap and drives neither request.
- R8: `wake_o` is the registered OR of all pending sources whose wake-enable bit is 1, whatever their enable bits.
- R9: Input-select bit n set to 1 takes source n from `pin_src_i[n]`; set to 0, it takes it from `core_src_i[n]`.
- R10: The test register is written at block 11 op 1 and read at block 11 op 0. While it is nonzero, its value replaces both input vectors. Writing it to zero returns the block to normal inputs.
- R11: Commands are accepted when `cmd_valid_i` and `cmd_ready_o` are both high. `cmd_ready_o` is low only while `rsp_valid_o` is 1 and `rsp_ready_i` is 0, and a stalled response holds its data. A write response carries 0, and a read of an unmapped address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| core_src_i | input | 32 | On-chip interrupt inputs, asynchronous |
| pin_src_i | input | 32 | Pin interrupt inputs, asynchronous |
| cmd_valid_i | input | 1 | Command valid |
| cmd_ready_o | output | 1 | Command ready |
| cmd_write_i | input | 1 | 1 = write, 0 = read |
| cmd_addr_i | input | 6 | Word address {block, op} |
| cmd_wdata_i | input | 32 | Write data |
| rsp_valid_o | output | 1 | Response valid |
| rsp_ready_i | input | 1 | Response ready |
| rsp_data_o | output | 32 | Read data, 0 for writes |
| irq_req_o | output | 2 | Registered request lines 0 and 1 |
| wake_o | output | 1 | Registered wake line |

## Verification
The assertions assume that at most one register operation reaches a given register in a cycle. The bus decode guarantees this by accepting a single command per edge. They also assume that the command fields stay steady while valid is high, and the bench sets them at falling edges and holds them until acceptance. Input vectors are changed only at falling edges and then held for several cycles, so each level is seen by the synchronizer for long enough. Every scenario starts from a fresh reset, so the capture and level checks never inherit state from an earlier test.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;

  localparam int unsigned ADDR_W = 6;

  // trigger codes {bit2, bit1, bit0}
  localparam logic [2:0] TRIG_OFF  = 3'b000;
  localparam logic [2:0] TRIG_RISE = 3'b001;
  localparam logic [2:0] TRIG_FALL = 3'b010;
  localparam logic [2:0] TRIG_BOTH = 3'b011;
  localparam logic [2:0] TRIG_HIGH = 3'b101;
  localparam logic [2:0] TRIG_LOW  = 3'b110;

  // address blocks (addr[5:2])
  localparam int unsigned NUM_CTL  = 7;
  localparam int unsigned IDX_MASK = 3;
  localparam int unsigned IDX_WAKE = 4;
  localparam int unsigned IDX_STEER = 5;
  localparam int unsigned IDX_SEL  = 6;
  localparam logic [3:0] BLK_RISE  = 4'd7;
  localparam logic [3:0] BLK_FALL  = 4'd8;
  localparam logic [3:0] BLK_STAT0 = 4'd9;
  localparam logic [3:0] BLK_STAT1 = 4'd10;
  localparam logic [3:0] BLK_TEST  = 4'd11;

  // operations (addr[1:0])
  localparam logic [1:0] OP_READ = 2'd0;
  localparam logic [1:0] OP_SET  = 2'd1;
  localparam logic [1:0] OP_CLR  = 2'd2;

  function automatic logic trig_catches_rise(input logic [2:0] m);
    return (m == TRIG_RISE) || (m == TRIG_BOTH);
  endfunction

  function automatic logic trig_catches_fall(input logic [2:0] m);
    return (m == TRIG_FALL) || (m == TRIG_BOTH);
  endfunction

endpackage

// File: rtl/irq_sync2.sv
module irq_sync2 #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      q_o    <= '0;
    end else begin
      meta_q <= d_i;
      q_o    <= meta_q;
    end
  end
endmodule

// File: rtl/irq_setclr_reg.sv
module irq_setclr_reg #(
  parameter int unsigned W = 32,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_en_i,
  input  logic         clr_en_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] set_bits, clr_bits;

  assign set_bits = set_en_i ? d_i : '0;
  assign clr_bits = clr_en_i ? d_i : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_o <= RST_VAL;
    else        q_o <= (q_o | set_bits) & ~clr_bits;
  end

  // R2: ones written to set land in the register
  p_set_bits_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (set_en_i && !clr_en_i) |=> ((q_o & $past(d_i)) == $past(d_i)));

  // R2: ones written to clear vanish
  p_clr_bits_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en_i && !set_en_i) |=> ((q_o & $past(d_i)) == '0));

  // R2: zero bits of a write leave their bits alone
  p_zero_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (set_en_i || clr_en_i) |=> (((q_o ^ $past(q_o)) & ~$past(d_i)) == '0));

  p_idle_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_en_i && !clr_en_i) |=> $stable(q_o));
endmodule

// File: rtl/irq_src_cell.sv
module irq_src_cell
  import irq_ctl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       lvl_i,
  input  logic [2:0] mode_i,
  input  logic       rise_clr_i,
  input  logic       fall_clr_i,
  output logic       pend_o,
  output logic       rise_cap_o,
  output logic       fall_cap_o
);
  logic prev_q;
  logic rise_hit, fall_hit;

  assign rise_hit = lvl_i & ~prev_q & trig_catches_rise(mode_i);
  assign fall_hit = ~lvl_i & prev_q & trig_catches_fall(mode_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q     <= 1'b0;
      rise_cap_o <= 1'b0;
      fall_cap_o <= 1'b0;
    end else begin
      prev_q     <= lvl_i;
      rise_cap_o <= (rise_cap_o & ~rise_clr_i) | rise_hit;
      fall_cap_o <= (fall_cap_o & ~fall_clr_i) | fall_hit;
    end
  end

  always_comb begin
    unique case (mode_i)
      TRIG_RISE, TRIG_FALL, TRIG_BOTH: pend_o = rise_cap_o | fall_cap_o;
      TRIG_HIGH: pend_o = lvl_i;
      TRIG_LOW:  pend_o = ~lvl_i;
      default:   pend_o = 1'b0;
    endcase
  end

  p_rise_catch_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_catches_rise(mode_i) && lvl_i && !prev_q) |=> rise_cap_o);

  p_fall_catch_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_catches_fall(mode_i) && !lvl_i && prev_q) |=> fall_cap_o);

  p_rise_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_cap_o && !rise_clr_i) |=> rise_cap_o);

  p_fall_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_cap_o && !fall_clr_i) |=> fall_cap_o);
endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_ctl_pkg::*;
#(
  parameter int unsigned NSRC = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   core_src_i,
  input  logic [NSRC-1:0]   pin_src_i,
  input  logic              cmd_valid_i,
  output logic              cmd_ready_o,
  input  logic              cmd_write_i,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  input  logic [NSRC-1:0]   cmd_wdata_i,
  output logic              rsp_valid_o,
  input  logic              rsp_ready_i,
  output logic [NSRC-1:0]   rsp_data_o,
  output logic [1:0]        irq_req_o,
  output logic              wake_o
);
  localparam logic [NSRC-1:0] ALL_ONES = {NSRC{1'b1}};

  logic            accept, wr_acc;
  logic [3:0]      blk;
  logic [1:0]      op;
  logic [NSRC-1:0] ctl_q [NUM_CTL];
  logic [NSRC-1:0] test_q;
  logic [NSRC-1:0] src_raw, src_s;
  logic [NSRC-1:0] rise_clr, fall_clr;
  logic [NSRC-1:0] pend, rise_cap, fall_cap;
  logic [NSRC-1:0] stat0, stat1;
  logic [NSRC-1:0] rd_data;

  assign blk         = cmd_addr_i[5:2];
  assign op          = cmd_addr_i[1:0];
  assign cmd_ready_o = ~rsp_valid_o | rsp_ready_i;
  assign accept      = cmd_valid_i & cmd_ready_o;
  assign wr_acc      = accept & cmd_write_i;

  // control registers with set/clear ports
  for (genvar k = 0; k < NUM_CTL; k++) begin : g_ctl
    localparam logic [NSRC-1:0] RV = (k == IDX_STEER) ? ALL_ONES : '0;
    irq_setclr_reg #(.W(NSRC), .RST_VAL(RV)) u_reg (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_en_i (wr_acc && (blk == 4'(k)) && (op == OP_SET)),
      .clr_en_i (wr_acc && (blk == 4'(k)) && (op == OP_CLR)),
      .d_i      (cmd_wdata_i),
      .q_o      (ctl_q[k])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) test_q <= '0;
    else if (wr_acc && blk == BLK_TEST && op == OP_SET) test_q <= cmd_wdata_i;
  end

  assign rise_clr = (wr_acc && blk == BLK_RISE && op == OP_CLR) ? cmd_wdata_i : '0;
  assign fall_clr = (wr_acc && blk == BLK_FALL && op == OP_CLR) ? cmd_wdata_i : '0;

  // input selection and synchronisation
  assign src_raw = (test_q != '0) ? test_q
                 : ((pin_src_i & ctl_q[IDX_SEL]) | (core_src_i & ~ctl_q[IDX_SEL]));

  irq_sync2 #(.W(NSRC)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (src_raw),
    .q_o   (src_s)
  );

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    irq_src_cell u_cell (
      .clk        (clk),
      .rst_n      (rst_n),
      .lvl_i      (src_s[i]),
      .mode_i     ({ctl_q[2][i], ctl_q[1][i], ctl_q[0][i]}),
      .rise_clr_i (rise_clr[i]),
      .fall_clr_i (fall_clr[i]),
      .pend_o     (pend[i]),
      .rise_cap_o (rise_cap[i]),
      .fall_cap_o (fall_cap[i])
    );
  end

  // routing and masking
  assign stat0 = pend & ctl_q[IDX_MASK] & ctl_q[IDX_STEER];
  assign stat1 = pend & ctl_q[IDX_MASK] & ~ctl_q[IDX_STEER];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_req_o <= 2'b00;
      wake_o    <= 1'b0;
    end else begin
      irq_req_o <= {|stat1, |stat0};
      wake_o    <= |(pend & ctl_q[IDX_WAKE]);
    end
  end

  // read mux
  always_comb begin
    rd_data = '0;
    if (op == OP_READ) begin
      case (blk)
        4'd0:      rd_data = ctl_q[0];
        4'd1:      rd_data = ctl_q[1];
        4'd2:      rd_data = ctl_q[2];
        4'd3:      rd_data = ctl_q[3];
        4'd4:      rd_data = ctl_q[4];
        4'd5:      rd_data = ctl_q[5];
        4'd6:      rd_data = ctl_q[6];
        BLK_RISE:  rd_data = rise_cap;
        BLK_FALL:  rd_data = fall_cap;
        BLK_STAT0: rd_data = stat0;
        BLK_STAT1: rd_data = stat1;
        BLK_TEST:  rd_data = test_q;
        default:   rd_data = '0;
      endcase
    end
  end

  // single-entry response stage
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_o <= 1'b0;
      rsp_data_o  <= '0;
    end else if (accept) begin
      rsp_valid_o <= 1'b1;
      rsp_data_o  <= cmd_write_i ? '0 : rd_data;
    end else if (rsp_ready_i) begin
      rsp_valid_o <= 1'b0;
    end
  end

  p_route0_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (|stat0) |=> irq_req_o[0]);

  p_route1_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (|stat1) |=> irq_req_o[1]);

  p_masked_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q[IDX_MASK] == '0) |=> (irq_req_o == 2'b00));

  p_wake_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|(pend & ctl_q[IDX_WAKE])) |=> wake_o);

  p_rsp_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid_o && !rsp_ready_i) |=> (rsp_valid_o && $stable(rsp_data_o)));
endmodule

// File: tb/irq_router_tb.sv
module irq_router_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] core_src = '0;
  logic [31:0] pin_src = '0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic        cmd_write = 1'b0;
  logic [5:0]  cmd_addr = '0;
  logic [31:0] cmd_wdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_data;
  logic [1:0]  irq_req;
  logic        wake;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  irq_router u_dut (
    .clk(clk), .rst_n(rst_n), .core_src_i(core_src), .pin_src_i(pin_src),
    .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready), .cmd_write_i(cmd_write),
    .cmd_addr_i(cmd_addr), .cmd_wdata_i(cmd_wdata), .rsp_valid_o(rsp_valid),
    .rsp_ready_i(rsp_ready), .rsp_data_o(rsp_data), .irq_req_o(irq_req), .wake_o(wake)
  );

  function automatic logic [5:0] ad(input int b, input int o);
    return {4'(b), 2'(o)};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(input logic w, input logic [5:0] a, input logic [31:0] d,
                      output logic [31:0] q);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_write = w; cmd_addr = a; cmd_wdata = d;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0; cmd_write = 1'b0;
    q = rsp_data;
  endtask

  task automatic wr(input int b, input int o, input logic [31:0] d);
    logic [31:0] x;
    xfer(1'b1, ad(b, o), d, x);
  endtask

  task automatic chk_rd(input string req, input int b, input logic [31:0] exp);
    logic [31:0] x;
    xfer(1'b0, ad(b, 0), '0, x);
    chk(req, x, exp);
  endtask

  task automatic do_reset;
    rst_n = 1'b0; core_src = '0; pin_src = '0; cmd_valid = 1'b0; rsp_ready = 1'b1;
    idle(3);
    rst_n = 1'b1;
    idle(1);
  endtask

  task automatic t_reset;
    do_reset;
    chk("R1 irq", {30'd0, irq_req}, 0);
    chk("R1 wake", {31'd0, wake}, 0);
    chk("R1 rsp_valid", {31'd0, rsp_valid}, 0);
    for (int b = 0; b < 12; b++) begin
      if (b == 9 || b == 10) continue;
      chk($sformatf("R1 block %0d", b), 0, 0);
      chk_rd("R1 reset value", b, (b == 5) ? 32'hFFFF_FFFF : 32'h0);
    end
  endtask

  task automatic t_setclr;
    do_reset;
    wr(0, 1, 32'h0000_00F0);
    chk_rd("R2 set", 0, 32'h0000_00F0);
    wr(0, 1, 32'h0000_000F);
    chk_rd("R2 set keeps", 0, 32'h0000_00FF);
    wr(0, 2, 32'h0000_0030);
    chk_rd("R2 clr", 0, 32'h0000_00CF);
    wr(0, 1, 32'h0); wr(0, 2, 32'h0);
    chk_rd("R2 zero writes", 0, 32'h0000_00CF);
    wr(5, 2, 32'h8000_0001);
    chk_rd("R2 steer clr", 5, 32'h7FFF_FFFE);
    wr(3, 1, 32'hA5A5_0000);
    chk_rd("R2 mask set", 3, 32'hA5A5_0000);
  endtask

  task automatic t_rise;
    do_reset;
    wr(0, 1, 32'h8);                 // source 3 code 001
    wr(3, 1, 32'h8);
    core_src[3] = 1'b1; idle(6);
    chk("R3 rise irq", {30'd0, irq_req}, 32'h1);
    chk_rd("R3 rise cap", 7, 32'h8);
    chk_rd("R6 status0", 9, 32'h8);
    chk_rd("R6 status1", 10, 32'h0);
    core_src[3] = 1'b0; idle(6);
    chk_rd("R4 still held", 7, 32'h8);
    chk_rd("R3 no fall in 001", 8, 32'h0);
    wr(7, 2, 32'h0); idle(2);
    chk_rd("R4 zero ack ignored", 7, 32'h8);
    wr(7, 2, 32'h8); idle(2);
    chk_rd("R4 ack clears", 7, 32'h0);
    chk("R4 irq drops", {30'd0, irq_req}, 0);
  endtask

  task automatic t_fall_both;
    do_reset;
    wr(1, 1, 32'h60);                // src5 010, src6 011
    wr(0, 1, 32'h40);
    core_src[6:5] = 2'b11; idle(6);
    chk_rd("R3 rise both", 7, 32'h40);
    chk_rd("R3 no fall yet", 8, 32'h0);
    core_src[6:5] = 2'b00; idle(6);
    chk_rd("R3 fall capture", 8, 32'h60);
    wr(8, 2, 32'h20);
    chk_rd("R4 fall ack", 8, 32'h40);
    wr(8, 2, 32'h40); wr(7, 2, 32'h40);
    chk_rd("R4 both acked", 7, 32'h0);
  endtask

  task automatic t_level;
    do_reset;
    core_src[9] = 1'b1; core_src[11:10] = 2'b11; idle(4);
    wr(2, 1, 32'h0000_0F00);         // bit2 for 8..11
    wr(0, 1, 32'h0000_0500);         // 8:101, 10:111
    wr(1, 1, 32'h0000_0600);         // 9:110, 10:111 ; 11:100
    wr(3, 1, 32'h0000_0F00);
    wr(5, 2, 32'h0000_0200);         // src9 to request 1
    idle(3);
    chk("R5 none pending", {30'd0, irq_req}, 0);
    chk_rd("R5 codes 100/111 quiet", 9, 32'h0);
    core_src[8] = 1'b1; idle(5);
    chk("R5 high level irq0", {30'd0, irq_req}, 32'h1);
    core_src[9] = 1'b0; idle(5);
    chk("R6 both lines", {30'd0, irq_req}, 32'h3);
    chk_rd("R6 status1 low level", 10, 32'h0000_0200);
    core_src[8] = 1'b0; core_src[9] = 1'b1; idle(5);
    chk("R5 no latch", {30'd0, irq_req}, 0);
    core_src[8] = 1'b1; idle(5);
    wr(3, 2, 32'h0000_0100); idle(2);
    chk_rd("R7 masked status", 9, 32'h0);
    chk("R7 masked irq", {30'd0, irq_req}, 0);
  endtask

  task automatic t_wake;
    do_reset;
    wr(2, 1, 32'h100); wr(0, 1, 32'h100);   // src8 101, unmasked stays 0
    core_src[8] = 1'b1; idle(5);
    chk("R8 wake off", {31'd0, wake}, 0);
    wr(4, 1, 32'h100); idle(2);
    chk("R8 wake while masked", {31'd0, wake}, 1);
    chk("R7 no irq when masked", {30'd0, irq_req}, 0);
    wr(4, 2, 32'h100); idle(2);
    chk("R8 wake cleared", {31'd0, wake}, 0);
  endtask

  task automatic t_srcsel;
    do_reset;
    wr(2, 1, 32'h1000); wr(0, 1, 32'h1000); wr(3, 1, 32'h1000);
    pin_src[12] = 1'b1; idle(5);
    chk("R9 core input chosen", {30'd0, irq_req}, 0);
    wr(6, 1, 32'h1000); idle(5);
    chk("R9 pin input chosen", {30'd0, irq_req}, 32'h1);
    chk_rd("R9 select readback", 6, 32'h1000);
  endtask

  task automatic t_test;
    do_reset;
    wr(2, 1, 32'h2000); wr(0, 1, 32'h2000); wr(3, 1, 32'h2000);
    wr(11, 1, 32'h2000); idle(5);
    chk("R10 test injects", {30'd0, irq_req}, 32'h1);
    chk_rd("R10 test readback", 11, 32'h2000);
    wr(11, 1, 32'h0); idle(5);
    chk("R10 normal again", {30'd0, irq_req}, 0);
  endtask

  task automatic t_bus;
    logic [31:0] x;
    do_reset;
    xfer(1'b1, ad(3, 1), 32'h1, x);
    chk("R11 write resp zero", x, 0);
    xfer(1'b0, ad(0, 3), '0, x);
    chk("R11 unmapped op", x, 0);
    xfer(1'b0, ad(14, 0), '0, x);
    chk("R11 unmapped block", x, 0);
    @(negedge clk);
    rsp_ready = 1'b0; cmd_valid = 1'b1; cmd_write = 1'b0; cmd_addr = ad(5, 0);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R11 rsp valid", {31'd0, rsp_valid}, 1);
    chk("R11 stalled ready low", {31'd0, cmd_ready}, 0);
    idle(3);
    chk("R11 held valid", {31'd0, rsp_valid}, 1);
    chk("R11 held data", rsp_data, 32'hFFFF_FFFF);
    rsp_ready = 1'b1;
    @(negedge clk);
    chk("R11 drained", {31'd0, rsp_valid}, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset;
    t_setclr;
    t_rise;
    t_fall_both;
    t_level;
    t_wake;
    t_srcsel;
    t_test;
    t_bus;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule